// File: doc/BRIEF.md
# MMU Control Register File

This block is the coprocessor-side register bank of a memory management unit. A core move-to-coprocessor operation presents a register number, a secondary register field (CRm), a 3-bit opcode2 field and a 32-bit value. The move-from operation uses the same register number to select the read data. Six registers hold MMU state: control, translation table base, domain access, fault status, fault address and process ID. Every write to them passes through a fixed mask that clears or forces the reserved bits.

Three further register numbers store nothing. Writes to them are commands. The CRm/opcode2 pair is decoded into single-cycle pulses for the caches, the TLBs, the write buffer and the read buffer, and the written value travels with the pulse as its address operand. A pair that no command uses raises an error flag for one cycle instead.

Top module: `mmu_ctrl_regs`

## Requirements
- R1: After a synchronous active-low reset, control reads 0x70. Translation base, domain access, fault status, fault address and process ID read 0. No command pulse and no error is raised.
- R2: A write to register 1 (control) stores (value & 0xFFFD) | 0x70. Bits 6:4 therefore always read 1, bit 1 always reads 0, and bits 31:16 always read 0.
- R3: Register 2 (translation base) keeps value & 0xFFFFC000. Register 3 (domain access) and register 6 (fault address) keep all 32 bits.
- R4: Register 5 (fault status) keeps value & 0xFF. Register 13 (process ID) keeps value & 0x7E000000.
- R5: `cp_rdata` is combinational from `cp_crn`. Register 0 returns the parameter DEV_ID (default 0x0A110001). Registers 4, 7 to 12, 14 and 15 return 0.
- R6: A write to register 0, 4, 10, 11, 12, 14 or 15 changes no stored register and raises no pulse and no error.
- R7: Register 7 (cache operations) decodes (opcode2, CRm) as follows. (0,7) sets pulse bits 0 and 1. (0,5) sets bit 0 (invalidate instruction cache). (0,6) sets bit 1 (invalidate data caches). (1,6) sets bit 2 (invalidate data line). (1,0xA) sets bit 3 (clean data line). (4,0xA) sets bit 4 (drain write buffer).
- R8: Register 8 (TLB operations) decodes (opcode2, CRm) as follows. (0,7) sets bits 5 and 6. (0,5) sets bit 5 (invalidate instruction TLB). (0,6) sets bit 6 (invalidate data TLB). (1,6) sets bit 7 (invalidate one data TLB entry).
- R9: Register 9 (read-buffer operations) decodes as follows. (0,0) sets bit 8 (invalidate all). opcode2 = 2 sets bit 9 (load) with `rb_index` = CRm[1:0] and `rb_type` = CRm[3:2]+1, accepted only when CRm[3:2] is not 3. opcode2 = 1 with CRm < 4 sets bit 10 (invalidate one entry) with `rb_index` = CRm[1:0].
- R10: Pulses appear on the clock edge after the strobed write, last exactly one cycle, and present the written value on `cmd_addr`.
- R11: A write to register 7, 8 or 9 whose pair matches no command raises `cmd_err` for one cycle and no pulse. This includes a read-buffer load with CRm[3:2] = 3.
- R12: A cycle without a write strobe, and any write to a storage register, leaves `cmd_pulse` at 0 and `cmd_err` low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cp_wr | input | 1 | Move-to-coprocessor write strobe |
| cp_crn | input | 4 | Register number for reads and writes |
| cp_crm | input | 4 | Secondary register field for operations |
| cp_op2 | input | 3 | Opcode2 field for operations |
| cp_wdata | input | 32 | Value written |
| cp_rdata | output | 32 | Combinational read data of register cp_crn |
| cmd_pulse | output | 11 | One-cycle command pulses, bit meanings per R7 to R9 |
| cmd_addr | output | 32 | Address operand carried with a pulse |
| rb_index | output | 2 | Read-buffer entry for load or single invalidate |
| rb_type | output | 2 | Read-buffer load type, 1 to 3 |
| cmd_err | output | 1 | One-cycle flag for an unrecognised operation |

## Verification
If a stored register holds a wrong value, the error shows on `cp_rdata` in the same cycle that the register number is presented. The bench compares the read data against its reference model on every clock, so an error is caught at the first read after the faulty write. A decode fault shows one edge after the strobe, as a wrong, missing or stretched pulse or error flag. A pulse carrying the wrong operand shows as a mismatch on `cmd_addr` or on the read-buffer fields in that same cycle. Random traffic interleaves command and data writes, so a pulse that leaks from one register number to another is also exposed.

// File: rtl/mmu_cr_pkg.sv
// Shared constants for the MMU control register file: register numbers,
// per-register write masks and command pulse bit positions.
// Assumes a 32-bit coprocessor data path.
package mmu_cr_pkg;

    localparam int W = 32;
    typedef logic [W-1:0] word_t;
    typedef logic [3:0]   crn_t;

    // Register numbers (decoded by the core's coprocessor field)
    localparam crn_t CRN_ID    = 4'd0;
    localparam crn_t CRN_CTRL  = 4'd1;
    localparam crn_t CRN_TTB   = 4'd2;
    localparam crn_t CRN_DAC   = 4'd3;
    localparam crn_t CRN_FSR   = 4'd5;
    localparam crn_t CRN_FAR   = 4'd6;
    localparam crn_t CRN_CACHE = 4'd7;
    localparam crn_t CRN_TLB   = 4'd8;
    localparam crn_t CRN_RBUF  = 4'd9;
    localparam crn_t CRN_PID   = 4'd13;

    // Storage slots: number, keep-mask, forced-one bits, reset value
    localparam int NSLOT = 6;
    localparam crn_t  SLOT_CRN [NSLOT] = '{CRN_CTRL, CRN_TTB, CRN_DAC,
                                           CRN_FSR, CRN_FAR, CRN_PID};
    localparam word_t SLOT_AND [NSLOT] = '{32'h0000_FFFD, 32'hFFFF_C000,
                                           32'hFFFF_FFFF, 32'h0000_00FF,
                                           32'hFFFF_FFFF, 32'h7E00_0000};
    localparam word_t SLOT_OR  [NSLOT] = '{32'h0000_0070, 32'h0, 32'h0,
                                           32'h0, 32'h0, 32'h0};
    localparam word_t SLOT_RST [NSLOT] = '{32'h0000_0070, 32'h0, 32'h0,
                                           32'h0, 32'h0, 32'h0};

    // Command pulse bit positions
    localparam int CMD_IC_INV        = 0;
    localparam int CMD_DC_INV        = 1;
    localparam int CMD_DC_INV_LINE   = 2;
    localparam int CMD_DC_CLEAN_LINE = 3;
    localparam int CMD_WB_DRAIN      = 4;
    localparam int CMD_ITLB_INV      = 5;
    localparam int CMD_DTLB_INV      = 6;
    localparam int CMD_DTLB_INV_ENT  = 7;
    localparam int CMD_RB_INV        = 8;
    localparam int CMD_RB_LOAD       = 9;
    localparam int CMD_RB_INV_ENT    = 10;
    localparam int NCMD              = 11;

    typedef logic [NCMD-1:0] cmd_t;

endpackage

// File: rtl/mmu_cr_store.sv
// Storage registers of the MMU control register file.
// One masked register per slot of the package table; a slot is written
// when the strobe is high and the register number matches its number.
// Assumes synchronous active-low reset.
module mmu_cr_store
    import mmu_cr_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  crn_t  crn,
    input  word_t wdata,
    output word_t slot_q [NSLOT]
);

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        // Masked write or reset of one storage register
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q[s] <= SLOT_RST[s];
            else if (wr_en && crn == SLOT_CRN[s])
                slot_q[s] <= (wdata & SLOT_AND[s]) | SLOT_OR[s];
        end
    end

endmodule

// File: rtl/mmu_cr_cmd_dec.sv
// Decoder for the operation register numbers (cache, TLB, read buffer).
// Turns a strobed (opcode2, CRm) pair into registered one-cycle pulses with
// the written value as operand, or a one-cycle error flag when the pair
// matches no command. Assumes synchronous active-low reset.
module mmu_cr_cmd_dec
    import mmu_cr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  crn_t       crn,
    input  logic [3:0] crm,
    input  logic [2:0] op2,
    input  word_t      wdata,
    output cmd_t       pulse_q,
    output word_t      addr_q,
    output logic [1:0] idx_q,
    output logic [1:0] type_q,
    output logic       err_q
);

    cmd_t       pulse_d;
    logic       err_d;
    logic [1:0] idx_d;
    logic [1:0] type_d;

    // Combinational decode of the operation pair for the addressed register
    always_comb begin
        pulse_d = '0;
        err_d   = 1'b0;
        idx_d   = crm[1:0];
        type_d  = 2'd0;
        case (crn)
            CRN_CACHE: begin
                if (op2 == 3'd0 && crm == 4'h7) begin
                    pulse_d[CMD_IC_INV] = 1'b1;
                    pulse_d[CMD_DC_INV] = 1'b1;
                end else if (op2 == 3'd0 && crm == 4'h5)
                    pulse_d[CMD_IC_INV] = 1'b1;
                else if (op2 == 3'd0 && crm == 4'h6)
                    pulse_d[CMD_DC_INV] = 1'b1;
                else if (op2 == 3'd1 && crm == 4'h6)
                    pulse_d[CMD_DC_INV_LINE] = 1'b1;
                else if (op2 == 3'd1 && crm == 4'hA)
                    pulse_d[CMD_DC_CLEAN_LINE] = 1'b1;
                else if (op2 == 3'd4 && crm == 4'hA)
                    pulse_d[CMD_WB_DRAIN] = 1'b1;
                else
                    err_d = 1'b1;
            end
            CRN_TLB: begin
                if (op2 == 3'd0 && crm == 4'h7) begin
                    pulse_d[CMD_ITLB_INV] = 1'b1;
                    pulse_d[CMD_DTLB_INV] = 1'b1;
                end else if (op2 == 3'd0 && crm == 4'h5)
                    pulse_d[CMD_ITLB_INV] = 1'b1;
                else if (op2 == 3'd0 && crm == 4'h6)
                    pulse_d[CMD_DTLB_INV] = 1'b1;
                else if (op2 == 3'd1 && crm == 4'h6)
                    pulse_d[CMD_DTLB_INV_ENT] = 1'b1;
                else
                    err_d = 1'b1;
            end
            CRN_RBUF: begin
                if (op2 == 3'd0 && crm == 4'h0)
                    pulse_d[CMD_RB_INV] = 1'b1;
                else if (op2 == 3'd2 && crm[3:2] != 2'd3) begin
                    pulse_d[CMD_RB_LOAD] = 1'b1;
                    type_d = crm[3:2] + 2'd1;
                end else if (op2 == 3'd1 && crm[3:2] == 2'd0)
                    pulse_d[CMD_RB_INV_ENT] = 1'b1;
                else
                    err_d = 1'b1;
            end
            default: ;
        endcase
    end

    // Register pulses and error for exactly one cycle after the strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q <= '0;
            err_q   <= 1'b0;
        end else begin
            pulse_q <= wr_en ? pulse_d : '0;
            err_q   <= wr_en & err_d;
        end
    end

    // Capture the operand and read-buffer fields alongside an issued command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            idx_q  <= '0;
            type_q <= '0;
        end else if (wr_en && pulse_d != '0) begin
            addr_q <= wdata;
            idx_q  <= idx_d;
            type_q <= type_d;
        end
    end

endmodule

// File: rtl/mmu_ctrl_regs.sv
// MMU control register file top: masked storage registers, the operation
// decoder and the combinational read multiplexer.
// Assumes reads and writes share the register number field; unknown
// numbers read as 0 and ignore writes.
module mmu_ctrl_regs
    import mmu_cr_pkg::*;
#(
    parameter logic [31:0] DEV_ID = 32'h0A11_0001
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cp_wr,
    input  logic [3:0]  cp_crn,
    input  logic [3:0]  cp_crm,
    input  logic [2:0]  cp_op2,
    input  logic [31:0] cp_wdata,
    output logic [31:0] cp_rdata,
    output logic [10:0] cmd_pulse,
    output logic [31:0] cmd_addr,
    output logic [1:0]  rb_index,
    output logic [1:0]  rb_type,
    output logic        cmd_err
);

    word_t slot_q [NSLOT];

    mmu_cr_store u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cp_wr),
        .crn   (cp_crn),
        .wdata (cp_wdata),
        .slot_q(slot_q)
    );

    mmu_cr_cmd_dec u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cp_wr),
        .crn    (cp_crn),
        .crm    (cp_crm),
        .op2    (cp_op2),
        .wdata  (cp_wdata),
        .pulse_q(cmd_pulse),
        .addr_q (cmd_addr),
        .idx_q  (rb_index),
        .type_q (rb_type),
        .err_q  (cmd_err)
    );

    // Read multiplexer: identity constant, storage slots, otherwise zero
    always_comb begin
        cp_rdata = '0;
        if (cp_crn == CRN_ID)
            cp_rdata = DEV_ID;
        for (int s = 0; s < NSLOT; s++) begin
            if (cp_crn == SLOT_CRN[s])
                cp_rdata = slot_q[s];
        end
    end

endmodule

// File: rtl/mmu_ctrl_regs_chk.sv
// Property checker for the MMU control register file, bound to the top.
// Assumes synchronous active-low reset on clk.
module mmu_ctrl_regs_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cp_wr,
    input logic [3:0]  cp_crn,
    input logic [31:0] cp_wdata,
    input logic [31:0] cp_rdata,
    input logic [10:0] cmd_pulse,
    input logic [31:0] cmd_addr,
    input logic        cmd_err
);

    AST_CTRL_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        cp_crn == 4'd1 |-> (cp_rdata[6:4] == 3'b111 && !cp_rdata[1] && cp_rdata[31:16] == 16'h0)); // R2

    AST_TTB_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cp_crn == 4'd2 |-> cp_rdata[13:0] == 14'h0); // R3

    AST_FSR_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cp_crn == 4'd5 |-> cp_rdata[31:8] == 24'h0); // R4

    AST_PID_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        cp_crn == 4'd13 |-> (cp_rdata & 32'h81FF_FFFF) == 32'h0); // R4

    AST_UNKNOWN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_crn == 4'd4 || cp_crn == 4'd15) |-> cp_rdata == 32'h0); // R5

    AST_OPERAND_CARRIED: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_pulse != 11'h0 |-> cmd_addr == $past(cp_wdata)); // R10

    AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> cmd_pulse == 11'h0); // R11

    AST_NO_STROBE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cp_wr) |-> (cmd_pulse == 11'h0 && !cmd_err)); // R12

endmodule

bind mmu_ctrl_regs mmu_ctrl_regs_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cp_wr    (cp_wr),
    .cp_crn   (cp_crn),
    .cp_wdata (cp_wdata),
    .cp_rdata (cp_rdata),
    .cmd_pulse(cmd_pulse),
    .cmd_addr (cmd_addr),
    .cmd_err  (cmd_err)
);

// File: tb/sim_mmu_ctrl_regs.sv
// Bench for the MMU control register file: behavioural reference model
// compared on every clock, plus directed checks per requirement.
module sim_mmu_ctrl_regs;

    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] EXP_ID     = 32'h0A11_0001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cp_wr = 1'b0;
    logic [3:0]  cp_crn = 4'd0;
    logic [3:0]  cp_crm = 4'd0;
    logic [2:0]  cp_op2 = 3'd0;
    logic [31:0] cp_wdata = 32'h0;
    logic [31:0] cp_rdata;
    logic [10:0] cmd_pulse;
    logic [31:0] cmd_addr;
    logic [1:0]  rb_index;
    logic [1:0]  rb_type;
    logic        cmd_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    bit live   = 0;

    mmu_ctrl_regs u0 (
        .clk(clk), .rst_n(rst_n), .cp_wr(cp_wr), .cp_crn(cp_crn),
        .cp_crm(cp_crm), .cp_op2(cp_op2), .cp_wdata(cp_wdata),
        .cp_rdata(cp_rdata), .cmd_pulse(cmd_pulse), .cmd_addr(cmd_addr),
        .rb_index(rb_index), .rb_type(rb_type), .cmd_err(cmd_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model state
    logic [31:0] m_ctrl, m_ttb, m_dac, m_fsr, m_far, m_pid;
    logic [10:0] m_pulse;
    logic        m_err;
    logic [31:0] m_addr;
    logic [1:0]  m_idx, m_type;

    function automatic logic [31:0] m_read(input logic [3:0] n);
        case (n)
            4'd0:  return EXP_ID;
            4'd1:  return m_ctrl;
            4'd2:  return m_ttb;
            4'd3:  return m_dac;
            4'd5:  return m_fsr;
            4'd6:  return m_far;
            4'd13: return m_pid;
            default: return 32'h0;
        endcase
    endfunction

    // Returns {err, idx, type, pulse} expected for a strobed write
    function automatic logic [15:0] m_cmd(input logic [3:0] n,
                                          input logic [3:0] cm,
                                          input logic [2:0] o2);
        logic [10:0] p = '0;
        logic e = 1'b0;
        logic [1:0] ix = 2'd0;
        logic [1:0] ty = 2'd0;
        int key = o2 * 16 + cm;
        if (n == 4'd7) begin
            if (key == 7) p = 11'b000_0000_0011;
            else if (key == 5) p = 11'b000_0000_0001;
            else if (key == 6) p = 11'b000_0000_0010;
            else if (key == 16 + 6) p = 11'b000_0000_0100;
            else if (key == 16 + 10) p = 11'b000_0000_1000;
            else if (key == 64 + 10) p = 11'b000_0001_0000;
            else e = 1'b1;
        end else if (n == 4'd8) begin
            if (key == 7) p = 11'b000_0110_0000;
            else if (key == 5) p = 11'b000_0010_0000;
            else if (key == 6) p = 11'b000_0100_0000;
            else if (key == 16 + 6) p = 11'b000_1000_0000;
            else e = 1'b1;
        end else if (n == 4'd9) begin
            if (key == 0) p = 11'b001_0000_0000;
            else if (o2 == 3'd2 && cm / 4 < 3) begin
                p = 11'b010_0000_0000; ix = cm % 4; ty = cm / 4 + 1;
            end else if (o2 == 3'd1 && cm < 4) begin
                p = 11'b100_0000_0000; ix = cm;
            end else e = 1'b1;
        end
        return {e, ix, ty, p};
    endfunction

    // Model update at every clock edge
    always @(posedge clk) begin
        logic [15:0] c;
        if (!rst_n) begin
            m_ctrl <= 32'h70; m_ttb <= 0; m_dac <= 0; m_fsr <= 0;
            m_far <= 0; m_pid <= 0; m_pulse <= 0; m_err <= 0;
            m_addr <= 0; m_idx <= 0; m_type <= 0;
        end else begin
            c = m_cmd(cp_crn, cp_crm, cp_op2);
            m_pulse <= cp_wr ? c[10:0] : 11'h0;
            m_err   <= cp_wr & c[15];
            if (cp_wr && c[10:0] != 0) begin
                m_addr <= cp_wdata; m_idx <= c[14:13]; m_type <= c[12:11];
            end
            if (cp_wr) begin
                case (cp_crn)
                    4'd1:  m_ctrl <= {16'h0, cp_wdata[15:0] | 16'h0070} & 32'hFFFD;
                    4'd2:  m_ttb  <= {cp_wdata[31:14], 14'h0};
                    4'd3:  m_dac  <= cp_wdata;
                    4'd5:  m_fsr  <= {24'h0, cp_wdata[7:0]};
                    4'd6:  m_far  <= cp_wdata;
                    4'd13: m_pid  <= {1'b0, cp_wdata[30:25], 25'h0};
                    default: ;
                endcase
            end
            live <= 1'b1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, got, exp, $time);
        end
    endtask

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (live && rst_n && !done) begin
            chk("R5 model rdata", cp_rdata, m_read(cp_crn));
            chk("R10 model pulse", {21'h0, cmd_pulse}, {21'h0, m_pulse});
            chk("R11 model err", {31'h0, cmd_err}, {31'h0, m_err});
            if (m_pulse != 0) begin
                chk("R10 model addr", cmd_addr, m_addr);
                if (m_pulse[9] || m_pulse[10])
                    chk("R9 model index", {30'h0, rb_index}, {30'h0, m_idx});
                if (m_pulse[9])
                    chk("R9 model type", {30'h0, rb_type}, {30'h0, m_type});
            end
        end
    end

    // Strobed write; returns at 2 time units after the capturing edge
    task automatic wr(input logic [3:0] n, input logic [3:0] cm,
                      input logic [2:0] o2, input logic [31:0] d);
        cp_crn = n; cp_crm = cm; cp_op2 = o2; cp_wdata = d; cp_wr = 1'b1;
        @(posedge clk); #2;
        cp_wr = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [3:0] n, input logic [31:0] exp);
        cp_crn = n;
        @(negedge clk);
        chk(tag, cp_rdata, exp);
        @(posedge clk); #2;
    endtask

    task automatic cmd(input string tag, input logic [3:0] n, input logic [3:0] cm,
                       input logic [2:0] o2, input logic [31:0] d,
                       input logic [10:0] exp_p, input logic exp_e);
        wr(n, cm, o2, d);
        @(negedge clk);
        chk(tag, {20'h0, cmd_err, cmd_pulse}, {20'h0, exp_e, exp_p});
        if (exp_p != 0) chk({tag, " addr"}, cmd_addr, d);
        @(posedge clk); #2;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pulse after reset", {21'h0, cmd_pulse}, 32'h0);
        chk("R1 err after reset", {31'h0, cmd_err}, 32'h0);
        @(posedge clk); #2;
        rd("R1 ctrl reset", 4'd1, 32'h70);
        rd("R1 ttb reset", 4'd2, 32'h0);
        rd("R1 dac reset", 4'd3, 32'h0);
        rd("R1 fsr reset", 4'd5, 32'h0);
        rd("R1 far reset", 4'd6, 32'h0);
        rd("R1 pid reset", 4'd13, 32'h0);
        rd("R5 id", 4'd0, EXP_ID);
        rd("R5 reg4", 4'd4, 32'h0);
        rd("R5 reg15", 4'd15, 32'h0);

        wr(4'd1, 0, 0, 32'hFFFF_FFFF); rd("R2 ctrl ones", 4'd1, 32'h0000_FFFD);
        wr(4'd1, 0, 0, 32'h0000_0000); rd("R2 ctrl zero", 4'd1, 32'h0000_0070);
        wr(4'd2, 0, 0, 32'hFFFF_FFFF); rd("R3 ttb", 4'd2, 32'hFFFF_C000);
        wr(4'd3, 0, 0, 32'hA5A5_1234); rd("R3 dac", 4'd3, 32'hA5A5_1234);
        wr(4'd6, 0, 0, 32'hDEAD_BEEF); rd("R3 far", 4'd6, 32'hDEAD_BEEF);
        wr(4'd5, 0, 0, 32'h0000_1234); rd("R4 fsr", 4'd5, 32'h0000_0034);
        wr(4'd13, 0, 0, 32'hFFFF_FFFF); rd("R4 pid", 4'd13, 32'h7E00_0000);

        cmd("R6 write reg4", 4'd4, 4'h7, 0, 32'h1111_1111, 11'h0, 1'b0);
        cmd("R6 write reg0", 4'd0, 4'h7, 0, 32'h2222_2222, 11'h0, 1'b0);
        cmd("R6 write reg10", 4'd10, 4'h0, 0, 32'h3333_3333, 11'h0, 1'b0);
        cmd("R6 write reg14", 4'd14, 4'h0, 0, 32'h4444_4444, 11'h0, 1'b0);
        cmd("R6 write reg15", 4'd15, 4'h0, 0, 32'h5555_5555, 11'h0, 1'b0);
        rd("R6 reg4 still zero", 4'd4, 32'h0);
        rd("R6 id unchanged", 4'd0, EXP_ID);
        rd("R6 dac unchanged", 4'd3, 32'hA5A5_1234);

        cmd("R12 data write quiet", 4'd3, 4'h7, 0, 32'h0, 11'h0, 1'b0);

        cmd("R7 inv all caches", 4'd7, 4'h7, 3'd0, 32'h1000_0000, 11'b000_0000_0011, 1'b0);
        cmd("R7 inv icache", 4'd7, 4'h5, 3'd0, 32'h1000_0004, 11'b000_0000_0001, 1'b0);
        cmd("R7 inv dcaches", 4'd7, 4'h6, 3'd0, 32'h1000_0008, 11'b000_0000_0010, 1'b0);
        cmd("R7 inv dline", 4'd7, 4'h6, 3'd1, 32'h1000_0020, 11'b000_0000_0100, 1'b0);
        cmd("R7 clean dline", 4'd7, 4'hA, 3'd1, 32'h1000_0040, 11'b000_0000_1000, 1'b0);
        cmd("R7 drain wb", 4'd7, 4'hA, 3'd4, 32'h1000_0080, 11'b000_0001_0000, 1'b0);

        cmd("R8 inv both tlbs", 4'd8, 4'h7, 3'd0, 32'h2000_0000, 11'b000_0110_0000, 1'b0);
        cmd("R8 inv itlb", 4'd8, 4'h5, 3'd0, 32'h2000_1000, 11'b000_0010_0000, 1'b0);
        cmd("R8 inv dtlb", 4'd8, 4'h6, 3'd0, 32'h2000_2000, 11'b000_0100_0000, 1'b0);
        cmd("R8 inv dtlb entry", 4'd8, 4'h6, 3'd1, 32'h2000_3000, 11'b000_1000_0000, 1'b0);

        cmd("R9 rb inv all", 4'd9, 4'h0, 3'd0, 32'h3000_0000, 11'b001_0000_0000, 1'b0);
        wr(4'd9, 4'b0110, 3'd2, 32'h3000_0100);
        @(negedge clk);
        chk("R9 rb load pulse", {21'h0, cmd_pulse}, {21'h0, 11'b010_0000_0000});
        chk("R9 rb load index", {30'h0, rb_index}, 32'd2);
        chk("R9 rb load type", {30'h0, rb_type}, 32'd2);
        @(posedge clk); #2;
        wr(4'd9, 4'h3, 3'd1, 32'h3000_0200);
        @(negedge clk);
        chk("R9 rb inv entry pulse", {21'h0, cmd_pulse}, {21'h0, 11'b100_0000_0000});
        chk("R9 rb inv entry index", {30'h0, rb_index}, 32'd3);
        @(posedge clk); #2;

        cmd("R11 rb load type4", 4'd9, 4'hC, 3'd2, 32'h0, 11'h0, 1'b1);
        cmd("R11 cache bad pair", 4'd7, 4'h0, 3'd3, 32'h0, 11'h0, 1'b1);
        cmd("R11 tlb bad pair", 4'd8, 4'h5, 3'd1, 32'h0, 11'h0, 1'b1);
        cmd("R11 rb inv entry crm4", 4'd9, 4'h4, 3'd1, 32'h0, 11'h0, 1'b1);

        // R10: back-to-back commands, then one idle cycle must be quiet
        wr(4'd7, 4'h5, 3'd0, 32'hAAAA_0000);
        wr(4'd8, 4'h6, 3'd0, 32'hBBBB_0000);
        @(negedge clk);
        chk("R10 second pulse", {21'h0, cmd_pulse}, {21'h0, 11'b000_0100_0000});
        chk("R10 second addr", cmd_addr, 32'hBBBB_0000);
        @(posedge clk); #2;
        @(negedge clk);
        chk("R10 pulse gone", {21'h0, cmd_pulse}, 32'h0);
        chk("R12 idle err low", {31'h0, cmd_err}, 32'h0);
        @(posedge clk); #2;

        // Random traffic against the per-clock model
        for (int i = 0; i < 400; i++) begin
            cp_crn   = 4'($urandom_range(0, 15));
            cp_crm   = 4'($urandom_range(0, 15));
            cp_op2   = 3'($urandom_range(0, 4));
            cp_wdata = $urandom;
            cp_wr    = ($urandom_range(0, 3) != 0);
            @(posedge clk); #2;
        end
        cp_wr = 1'b0;
        repeat (2) @(posedge clk);
        #2;
        finish_run();
    end

endmodule